// File: doc/BRIEF.md
# Soft-Start and Headroom Reference Sequencer

This block brings a switched-mode LED supply up from rest and then keeps its error-amplifier reference at the lowest level that still gives every LED current sink enough headroom. The reference is a 9-bit code that drives an external DAC with a step of about 1.95 mV. The comparators and the DAC are analog parts and lie outside the block. Here they appear only as digital inputs and as the code output.

When enabled, the sequencer first looks at the results of the sink short-to-ground check. It then turns on the external pass-transistor gate drive, waits a fixed settle time, and starts switching. During a fixed-length ramp stage it raises the code one LSB per step tick until the feedback-threshold comparator trips. At the end of that stage it samples a low-feedback comparator. A low reading is a fault, and the fault holds until enable is cleared. Once the ramp has finished and the dimming input is high, the block enters regulation. In regulation each dimming rising edge, or each hold period while dimming stays high, moves the code by at most one step. The direction comes from the window comparators of the sinks that have not been flagged open.

Top module: `softstart_ref_seq`

## Requirements
- R1: After reset, and while idle, `state_o` is 0 (idle), `code_o` is 0, and `cp_en_o`, `sw_en_o` and `fault_o` are low. The state encoding is: 0 idle, 1 short check, 2 gate settle, 3 ramp, 4 wait for dimming, 5 regulate, 6 fault.
- R2: In the short-check cycle, if any bit of `sg_short_i` is set, the block goes to the fault state (`fault_o` high). Switching never starts until enable is cleared.
- R3: The gate-settle state lasts `STG1_CYC` cycles. During it `cp_en_o` is high and `sw_en_o` is low. In states 3, 4 and 5 both enables are high.
- R4: In the ramp state the code rises by one every `STEP_CYC` cycles while `fb_thr_i` is low, and it stops rising while `fb_thr_i` is high. The ramp state lasts `STG2_CYC` cycles, or `STG2F_CYC` cycles if `fast_ss_i` was high when enable rose.
- R5: If `fb_low_i` is high on the last ramp cycle, the block enters the fault state. Both enables go low and the fault holds until `en_i` is cleared.
- R6: If `fb_low_i` is low at the end of the ramp, the block waits in state 4 with the code unchanged. It enters regulation (state 5) once the synchronized dimming input is high. On entry the code is clamped into [`CODE_MIN`, `CODE_MAX`].
- R7: In regulation the code steps once on each rising edge of `dim_i`, and once every `HOLD_CYC` cycles while `dim_i` stays high. The step is +1 if any active channel has `win_lo_i` set. Otherwise it is -1 if every active channel has `win_hi_i` set. In all other cases the code holds.
- R8: In regulation the code never leaves [`CODE_MIN`, `CODE_MAX`]. Further up-steps at the top and down-steps at the bottom have no effect.
- R9: A channel whose `open_i` bit has been seen high is no longer active. It stays removed from the direction decision until the block returns to idle.
- R10: In regulation, `fb_uv_i` high moves the block to the fault state.
- R11: When `en_i` is low, the block is in idle with the code at 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sequencer enable |
| fast_ss_i | input | 1 | Shortened ramp, latched when enable rises |
| sg_short_i | input | N_CH | Per-sink short-to-ground check results |
| fb_thr_i | input | 1 | Feedback has reached the ramp target |
| fb_low_i | input | 1 | Feedback is below the ramp pass level |
| fb_uv_i | input | 1 | Feedback undervoltage |
| win_lo_i | input | N_CH | Sink voltage below the window |
| win_hi_i | input | N_CH | Sink voltage above the window |
| open_i | input | N_CH | Open-string flags |
| dim_i | input | 1 | Dimming input, asynchronous |
| code_o | output | CODE_W | Reference DAC code |
| cp_en_o | output | 1 | Gate charge-pump enable |
| sw_en_o | output | 1 | Converter switching enable |
| fault_o | output | 1 | Sequencer fault |
| state_o | output | 3 | Sequencer state |

## Verification
Regulation is exercised with a table of window patterns. The patterns cover no flags, a single low flag, all sinks high, all but one sink high, low and high flags mixed, and high flags with progressively opened channels. Together they separate the up priority from the all-high down rule and confirm that a masked channel can neither trigger nor veto a step. Separate runs check the following:
- The dimming edge and the held-high timer are told apart by sampling before and after one hold period.
- The slow and fast ramps are distinguished by the state at a point between the two stage lengths.
- Long held-high runs drive the code into both clamps.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SGCHK   = 3'd1,
    ST_STG1    = 3'd2,
    ST_STG2    = 3'd3,
    ST_WAITDIM = 3'd4,
    ST_REG     = 3'd5,
    ST_FAULT   = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;

endpackage

// File: rtl/ss_dim_tracker.sv
module ss_dim_tracker #(
  parameter int HOLD_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dim_i,
  input  logic run_i,
  output logic dim_s_o,
  output logic upd_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          sync1_q, sync2_q, dim_q;
  logic [HW-1:0] hold_q;
  logic          rise, hold_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      dim_q   <= 1'b0;
    end else begin
      sync1_q <= dim_i;
      sync2_q <= sync1_q;
      dim_q   <= sync2_q;
    end
  end

  assign rise     = sync2_q & ~dim_q;
  assign hold_hit = sync2_q & ~rise & (hold_q == HW'(HOLD_CYC - 1));

  // hold timer restarts on every edge so the period is measured from it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hold_q <= '0;
    else if (!run_i || !sync2_q || rise)  hold_q <= '0;
    else if (hold_hit)                    hold_q <= '0;
    else                                  hold_q <= hold_q + 1'b1;
  end

  assign dim_s_o = sync2_q;
  assign upd_o   = run_i & (rise | hold_hit);

  AST_NO_UPD_DIM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !sync2_q) |-> !upd_o); // R7

endmodule

// File: rtl/ss_dir_sel.sv
module ss_dir_sel
  import ss_seq_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [N_CH-1:0] open_i,
  input  logic [N_CH-1:0] lo_i,
  input  logic [N_CH-1:0] hi_i,
  output step_dir_e       dir_o
);
  logic [N_CH-1:0] mask_q, act, lo_act, hi_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else            mask_q <= mask_q | open_i;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign act[c]    = ~(mask_q[c] | open_i[c]);
    assign lo_act[c] = act[c] & lo_i[c];
    assign hi_ok[c]  = ~act[c] | hi_i[c];
  end

  always_comb begin
    if (|lo_act)              dir_o = DIR_UP;
    else if ((|act) && &hi_ok) dir_o = DIR_DOWN;
    else                      dir_o = DIR_HOLD;
  end

  AST_OPEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R9

endmodule

// File: rtl/ss_code_ctl.sv
module ss_code_ctl
  import ss_seq_pkg::*;
#(
  parameter int CODE_W   = 9,
  parameter int CODE_MIN = 246,
  parameter int CODE_MAX = 511
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zero_i,
  input  logic              clamp_i,
  input  logic              inc_i,
  input  logic              upd_i,
  input  step_dir_e         dir_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CMIN = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] CMAX = CODE_W'(CODE_MAX);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (zero_i) begin
      code_d = '0;
    end else if (clamp_i) begin
      if (code_q < CMIN)      code_d = CMIN;
      else if (code_q > CMAX) code_d = CMAX;
    end else if (upd_i) begin
      if (dir_i == DIR_UP && code_q < CMAX)        code_d = code_q + 1'b1;
      else if (dir_i == DIR_DOWN && code_q > CMIN) code_d = code_q - 1'b1;
    end else if (inc_i && code_q < CMAX) begin
      code_d = code_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  AST_CODE_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= CMAX); // R8

endmodule

// File: rtl/softstart_ref_seq.sv
module softstart_ref_seq
  import ss_seq_pkg::*;
#(
  parameter int N_CH      = 4,
  parameter int CODE_W    = 9,
  parameter int CODE_MIN  = 246,
  parameter int CODE_MAX  = 511,
  parameter int STG1_CYC  = 2000,
  parameter int STG2_CYC  = 50000,
  parameter int STG2F_CYC = 25000,
  parameter int STEP_CYC  = 64,
  parameter int HOLD_CYC  = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fast_ss_i,
  input  logic [N_CH-1:0]   sg_short_i,
  input  logic              fb_thr_i,
  input  logic              fb_low_i,
  input  logic              fb_uv_i,
  input  logic [N_CH-1:0]   win_lo_i,
  input  logic [N_CH-1:0]   win_hi_i,
  input  logic [N_CH-1:0]   open_i,
  input  logic              dim_i,
  output logic [CODE_W-1:0] code_o,
  output logic              cp_en_o,
  output logic              sw_en_o,
  output logic              fault_o,
  output logic [2:0]        state_o
);
  localparam int TMR_W  = $clog2(STG1_CYC + STG2_CYC + STG2F_CYC + 1);
  localparam int STEP_W = $clog2(STEP_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_TOP = '1;

  seq_state_e        state_q, state_n;
  logic [TMR_W-1:0]  tmr_q, stg2_last;
  logic [STEP_W-1:0] step_q;
  logic              fast_q, step_hit, inc, clamp, dim_s, upd;
  step_dir_e         dir;

  ss_dim_tracker #(.HOLD_CYC(HOLD_CYC)) u_dim (
    .clk_i, .rst_ni, .dim_i,
    .run_i  (state_q == ST_REG),
    .dim_s_o(dim_s),
    .upd_o  (upd)
  );

  ss_dir_sel #(.N_CH(N_CH)) u_dir (
    .clk_i, .rst_ni,
    .clr_i (state_q == ST_IDLE),
    .open_i,
    .lo_i  (win_lo_i),
    .hi_i  (win_hi_i),
    .dir_o (dir)
  );

  ss_code_ctl #(.CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) u_code (
    .clk_i, .rst_ni,
    .zero_i (!en_i),
    .clamp_i(clamp),
    .inc_i  (inc),
    .upd_i  (upd && en_i && !fb_uv_i),
    .dir_i  (dir),
    .code_o (code_o)
  );

  assign stg2_last = fast_q ? TMR_W'(STG2F_CYC - 1) : TMR_W'(STG2_CYC - 1);
  assign step_hit  = (state_q == ST_STG2) && (step_q == STEP_W'(STEP_CYC - 1));

  always_comb begin
    state_n = state_q;
    inc     = 1'b0;
    clamp   = 1'b0;
    if (!en_i) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_n = ST_SGCHK;
        ST_SGCHK: state_n = (|sg_short_i) ? ST_FAULT : ST_STG1;
        ST_STG1:  if (tmr_q == TMR_W'(STG1_CYC - 1)) state_n = ST_STG2;
        ST_STG2: begin
          inc = step_hit && !fb_thr_i;
          if (tmr_q == stg2_last) state_n = fb_low_i ? ST_FAULT : ST_WAITDIM;
        end
        ST_WAITDIM: if (dim_s) begin
          state_n = ST_REG;
          clamp   = 1'b1;
        end
        ST_REG:   if (fb_uv_i) state_n = ST_FAULT;
        ST_FAULT: state_n = ST_FAULT;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      step_q  <= '0;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (state_n != state_q)  tmr_q <= '0;
      else if (tmr_q != TMR_TOP) tmr_q <= tmr_q + 1'b1;
      if (state_q != ST_STG2 || step_hit) step_q <= '0;
      else                                step_q <= step_q + 1'b1;
      if (state_q == ST_IDLE && en_i) fast_q <= fast_ss_i;
    end
  end

  assign cp_en_o = (state_q == ST_STG1) || (state_q == ST_STG2) ||
                   (state_q == ST_WAITDIM) || (state_q == ST_REG);
  assign sw_en_o = (state_q == ST_STG2) || (state_q == ST_WAITDIM) ||
                   (state_q == ST_REG);
  assign fault_o = (state_q == ST_FAULT);
  assign state_o = state_q;

  AST_SG_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SGCHK && en_i && |sg_short_i) |=> (state_q == ST_FAULT)); // R2
  AST_FAULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT && en_i) |=> (state_q == ST_FAULT)); // R5
  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STG2 && en_i) |=>
      (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1)); // R4
  AST_REG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REG && en_i) |=>
      (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1 ||
       code_o == $past(code_o) - 1'b1)); // R7
  AST_REG_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REG) |->
      (code_o >= CODE_W'(CODE_MIN) && code_o <= CODE_W'(CODE_MAX))); // R8
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE && code_o == '0)); // R11

endmodule

// File: tb/softstart_ref_seq_bench.sv
module softstart_ref_seq_bench;
  localparam int N_CH = 4;
  localparam int CW   = 9;
  localparam int CMIN = 20;
  localparam int CMAX = 60;
  localparam int S1   = 20;
  localparam int S2   = 200;
  localparam int S2F  = 100;
  localparam int STP  = 4;
  localparam int HLD  = 50;

  // {lo[3:0], hi[3:0], open[3:0], exp: 0 hold, 1 up, 2 down}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 4'b0000, 2'd0},
    {4'b0001, 4'b0000, 4'b0000, 2'd1},
    {4'b0000, 4'b1111, 4'b0000, 2'd2},
    {4'b0000, 4'b0111, 4'b0000, 2'd0},
    {4'b1000, 4'b1111, 4'b0000, 2'd1},
    {4'b0100, 4'b0000, 4'b0000, 2'd1},
    {4'b0000, 4'b1110, 4'b0001, 2'd2},
    {4'b0001, 4'b0000, 4'b0000, 2'd0},
    {4'b0000, 4'b1100, 4'b0010, 2'd2},
    {4'b0010, 4'b0000, 4'b0000, 2'd0},
    {4'b1000, 4'b0000, 4'b0000, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, fast = 0, fb_low = 0, fb_uv = 0, dim = 0;
  logic [N_CH-1:0] sg = '0, lo = '0, hi = '0, opn = '0;
  logic [CW-1:0] code;
  logic cp_en, sw_en, fault, fb_thr;
  logic [2:0] state;
  int tgt = 30;
  int n_chk = 0, n_bad = 0;
  int cur;

  always #2.5 clk = ~clk;
  assign fb_thr = int'(code) >= tgt;

  softstart_ref_seq #(
    .N_CH(N_CH), .CODE_W(CW), .CODE_MIN(CMIN), .CODE_MAX(CMAX),
    .STG1_CYC(S1), .STG2_CYC(S2), .STG2F_CYC(S2F), .STEP_CYC(STP), .HOLD_CYC(HLD)
  ) u_softstart_ref_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fast_ss_i(fast), .sg_short_i(sg),
    .fb_thr_i(fb_thr), .fb_low_i(fb_low), .fb_uv_i(fb_uv), .win_lo_i(lo),
    .win_hi_i(hi), .open_i(opn), .dim_i(dim), .code_o(code), .cp_en_o(cp_en),
    .sw_en_o(sw_en), .fault_o(fault), .state_o(state)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    chk("R1 state", state, 0); chk("R1 code", code, 0);
    chk("R1 enables", {cp_en, sw_en, fault}, 0);

    // R2 short at startup
    sg = 4'b0001; en = 1; wait_n(5);
    chk("R2 fault state", state, 6); chk("R2 fault", fault, 1);
    wait_n(100);
    chk("R2 no switching", sw_en, 0);
    en = 0; wait_n(3);
    chk("R11 idle", state, 0); chk("R11 code", code, 0);
    sg = '0;

    // normal start
    en = 1; wait_n(10);
    chk("R3 settle state", state, 2); chk("R3 cp_en", cp_en, 1); chk("R3 sw_en off", sw_en, 0);
    wait_n(20);
    chk("R3 ramp state", state, 3); chk("R3 sw_en on", sw_en, 1);
    wait_n(120);
    chk("R4 ramp stops at target", code, 30); chk("R4 still ramping", state, 3);
    wait_n(82);
    chk("R6 waits for dim", state, 4); chk("R6 code held", code, 30);
    dim = 1; wait_n(8);
    chk("R6 regulate", state, 5); chk("R6 entry code", code, 30);

    // R7 R9 direction table
    cur = 30;
    for (int i = 0; i < NV; i++) begin
      dim = 0;
      lo = VEC[i][13:10]; hi = VEC[i][9:6]; opn = VEC[i][5:2];
      wait_n(6);
      dim = 1; wait_n(8);
      if (VEC[i][1:0] == 2'd1) cur++;
      else if (VEC[i][1:0] == 2'd2) cur--;
      chk($sformatf("R7 R9 vector %0d", i), code, cur);
    end
    opn = '0;

    // R7 hold timer
    dim = 0; lo = 4'b0100; hi = '0; wait_n(6);
    dim = 1; wait_n(28);
    chk("R7 edge step", code, cur + 1);
    wait_n(52);
    chk("R7 hold step", code, cur + 2);

    // R8 clamps
    wait_n(45 * HLD);
    chk("R8 upper clamp", code, CMAX);
    lo = '0; hi = 4'b1100; wait_n(45 * HLD);
    chk("R8 lower clamp", code, CMIN);

    // R10 undervoltage
    fb_uv = 1; wait_n(5);
    chk("R10 fault", state, 6); chk("R10 sw off", sw_en, 0);
    fb_uv = 0; en = 0; dim = 0; hi = '0; wait_n(3);
    chk("R11 idle after fault", state, 0); chk("R11 code zero", code, 0);

    // R5 low feedback at ramp end
    fb_low = 1; en = 1; wait_n(260);
    chk("R5 fault", state, 6); chk("R5 cp off", cp_en, 0);
    fb_low = 0; wait_n(50);
    chk("R5 latched", fault, 1);
    en = 0; wait_n(3);

    // R4 fast ramp
    fast = 1; en = 1; wait_n(142);
    chk("R4 fast ramp ended", state, 4);
    en = 0; wait_n(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule